// File: doc/BRIEF.md
# CPU Core Power-Up Sequencer

This block is a small hardware state machine that brings one processor core out of its powered-off state. A single start pulse launches a fixed series of writes to two control words. The first is an 8-bit core power-control word that drives the clamps, the memory head switch, the resets and the powered-up flag. The second is a 32-bit power-gate word that enables the head switch and gives it a switching count. Between some of the steps the machine waits a programmable time, counted in clock cycles.

The wait is two microseconds. The `CYCLES_PER_US` parameter converts it to cycles, so each wait lasts `W = WAIT_US * CYCLES_PER_US` cycles, and `WAIT_US` defaults to 2. The block does not model the switches, the clamps or the core. It only drives the words in the right order and reports its progress through a busy level and a one-cycle done pulse.

Top module: `core_pwrup_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, the control word and the gate word are zero, and busy and done are low. Asserting reset in the middle of a sequence returns the outputs to this state and the machine to idle.
- R2: A start pulse seen in idle sets the control word to 0x33 on the next edge and the gate word to zero. The bit meanings are: bit0 logic clamp, bit1 memory clamp, bit2 L1 reset disable, bit3 memory head switch, bit4 core reset, bit5 power-on reset, bit6 clock gate, bit7 powered-up. The same edge raises busy.
- R3: One cycle after R2, the gate word becomes 0x1000_0001. Bit0 is the head-switch enable, and bits 31:24 hold the count 16.
- R4: W cycles after the gate word is written, the memory clamp (bit1) clears, and the control word becomes 0x31.
- R5: One cycle after R4, the memory head switch (bit3) sets, and the control word becomes 0x39.
- R6: W cycles after R5, the logic clamp (bit0) clears, and the control word becomes 0x38. The logic clamp is never released while the memory head switch is off.
- R7: W cycles after R6, both reset bits (bit4 and bit5) clear on the same edge, and the control word becomes 0x08.
- R8: One cycle after R7, the powered-up bit (bit7) sets, giving 0x88. On that same edge busy falls and done rises for exactly one cycle.
- R9: A start pulse that arrives while busy is high has no effect on the sequence or its timing.
- R10: Bit2 and bit6 of the control word stay zero at all times.
- R11: After completion, both words hold their final values until the next start. A new start runs the whole sequence again from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled only in idle |
| core_ctrl | output | 8 | Core power-control word |
| gate_ctrl | output | 32 | Power-gate control word |
| busy | output | 1 | High while a sequence is in progress |
| done | output | 1 | One-cycle pulse when the core is powered up |

## Verification
The main sequence runs three ways: from the reset state, again straight after a completed run, and with extra start pulses injected during the waits. The first run checks every step's value and exact cycle. The second separates a design that restarts cleanly, including clearing the gate word, from one that keeps stale state. The third separates a design that ignores start while busy from one that restarts or shifts its timing. A reset asserted part-way through a wait shows that the machine abandons the sequence and returns its outputs to zero. After each completed run, the outputs are watched over an idle stretch to confirm they hold.

// File: rtl/core_pwrup_pkg.sv
package core_pwrup_pkg;

   localparam int CTRL_W = 8;

   // control word bit positions (decoded by the power switch fabric)
   localparam int B_LOGIC_CLAMP = 0;
   localparam int B_MEM_CLAMP   = 1;
   localparam int B_L1_RST_DIS  = 2;
   localparam int B_MEM_HS      = 3;
   localparam int B_CORE_RST    = 4;
   localparam int B_POR_RST     = 5;
   localparam int B_CLK_GATE    = 6;
   localparam int B_PWRD_UP     = 7;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_GATE       = 3'd1,
      ST_MEM_WAIT   = 3'd2,
      ST_MEM_HS     = 3'd3,
      ST_HS_WAIT    = 3'd4,
      ST_CLAMP_WAIT = 3'd5,
      ST_PWRD       = 3'd6
   } pwrup_state_e;

endpackage

// File: rtl/pwrup_wait_timer.sv
module pwrup_wait_timer #(
   parameter int WAIT_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic expired
);

   localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

   generate
      if (WAIT_CYC < 1) begin : g_bad
         $error("pwrup_wait_timer: WAIT_CYC must be at least 1");
      end

      if (WAIT_CYC == 1) begin : g_single
         // a one-cycle wait needs no storage
         assign expired = 1'b1;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYC - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (load) begin
               cnt_q <= LOAD_VAL;
            end else if (run && (cnt_q != '0)) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign expired = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/pwrup_step_fsm.sv
module pwrup_step_fsm
   import core_pwrup_pkg::*;
#(
   parameter int GATE_W       = 32,
   parameter int HS_COUNT     = 16,
   parameter int HS_COUNT_LSB = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wait_expired,
   output logic              wait_load,
   output logic              wait_run,
   output logic [CTRL_W-1:0] core_ctrl,
   output logic [GATE_W-1:0] gate_ctrl,
   output logic              busy,
   output logic              done
);

   localparam int HS_CNT_W = GATE_W - HS_COUNT_LSB;
   localparam logic [GATE_W-1:0] GATE_ON =
      (GATE_W'(HS_COUNT) << HS_COUNT_LSB) | GATE_W'(1);

   localparam logic [CTRL_W-1:0] CTRL_INIT =
      (CTRL_W'(1) << B_LOGIC_CLAMP) | (CTRL_W'(1) << B_MEM_CLAMP) |
      (CTRL_W'(1) << B_CORE_RST)    | (CTRL_W'(1) << B_POR_RST);

   generate
      if (HS_COUNT_LSB < 1 || HS_COUNT_LSB >= GATE_W) begin : g_bad_lsb
         $error("pwrup_step_fsm: HS_COUNT_LSB out of range");
      end
      if (HS_COUNT >= (1 << HS_CNT_W)) begin : g_bad_cnt
         $error("pwrup_step_fsm: HS_COUNT does not fit its field");
      end
   endgenerate

   pwrup_state_e      st_q, st_d;
   logic [CTRL_W-1:0] ctrl_q, ctrl_d;
   logic [GATE_W-1:0] gate_q, gate_d;
   logic              done_q, done_d;

   always_comb begin
      st_d      = st_q;
      ctrl_d    = ctrl_q;
      gate_d    = gate_q;
      done_d    = 1'b0;
      wait_load = 1'b0;
      wait_run  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               ctrl_d = CTRL_INIT;
               gate_d = '0;
               st_d   = ST_GATE;
            end
         end
         ST_GATE: begin
            gate_d    = GATE_ON;
            wait_load = 1'b1;
            st_d      = ST_MEM_WAIT;
         end
         ST_MEM_WAIT: begin
            wait_run = 1'b1;
            if (wait_expired) begin
               ctrl_d[B_MEM_CLAMP] = 1'b0;
               st_d                = ST_MEM_HS;
            end
         end
         ST_MEM_HS: begin
            ctrl_d[B_MEM_HS] = 1'b1;
            wait_load        = 1'b1;
            st_d             = ST_HS_WAIT;
         end
         ST_HS_WAIT: begin
            wait_run = 1'b1;
            if (wait_expired) begin
               ctrl_d[B_LOGIC_CLAMP] = 1'b0;
               wait_load             = 1'b1;
               st_d                  = ST_CLAMP_WAIT;
            end
         end
         ST_CLAMP_WAIT: begin
            wait_run = 1'b1;
            if (wait_expired) begin
               ctrl_d[B_CORE_RST] = 1'b0;
               ctrl_d[B_POR_RST]  = 1'b0;
               st_d               = ST_PWRD;
            end
         end
         ST_PWRD: begin
            ctrl_d[B_PWRD_UP] = 1'b1;
            done_d            = 1'b1;
            st_d              = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ctrl_q <= '0;
         gate_q <= '0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         ctrl_q <= ctrl_d;
         gate_q <= gate_d;
         done_q <= done_d;
      end
   end

   assign core_ctrl = ctrl_q;
   assign gate_ctrl = gate_q;
   assign busy      = (st_q != ST_IDLE);
   assign done      = done_q;

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
   import core_pwrup_pkg::*;
#(
   parameter int CYCLES_PER_US = 50,
   parameter int WAIT_US       = 2,
   parameter int GATE_W        = 32,
   parameter int HS_COUNT      = 16,
   parameter int HS_COUNT_LSB  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic [CTRL_W-1:0] core_ctrl,
   output logic [GATE_W-1:0] gate_ctrl,
   output logic              busy,
   output logic              done
);

   localparam int WAIT_CYC = WAIT_US * CYCLES_PER_US;

   generate
      if (CYCLES_PER_US < 1 || WAIT_US < 1) begin : g_bad_wait
         $error("core_pwrup_seq: wait parameters must be positive");
      end
   endgenerate

   logic wait_load;
   logic wait_run;
   logic wait_expired;

   pwrup_wait_timer #(
      .WAIT_CYC (WAIT_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (wait_load),
      .run     (wait_run),
      .expired (wait_expired)
   );

   pwrup_step_fsm #(
      .GATE_W       (GATE_W),
      .HS_COUNT     (HS_COUNT),
      .HS_COUNT_LSB (HS_COUNT_LSB)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .wait_expired (wait_expired),
      .wait_load    (wait_load),
      .wait_run     (wait_run),
      .core_ctrl    (core_ctrl),
      .gate_ctrl    (gate_ctrl),
      .busy         (busy),
      .done         (done)
   );

endmodule

// File: rtl/core_pwrup_seq_chk.sv
module core_pwrup_seq_chk #(
   parameter int GATE_W       = 32,
   parameter int HS_COUNT     = 16,
   parameter int HS_COUNT_LSB = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [7:0]        core_ctrl,
   input logic [GATE_W-1:0] gate_ctrl,
   input logic              busy,
   input logic              done
);

   localparam logic [GATE_W-1:0] GATE_ON =
      (GATE_W'(HS_COUNT) << HS_COUNT_LSB) | GATE_W'(1);

   // R8
   done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_final_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (core_ctrl == 8'h88) && !busy);

   // R10
   reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_ctrl[2] == 1'b0) && (core_ctrl[6] == 1'b0));

   // R7
   resets_paired_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_ctrl[4] == core_ctrl[5]);

   // R6
   clamp_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((core_ctrl != 8'h00) && !core_ctrl[0]) |-> core_ctrl[3]);

   // R3
   gate_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_ctrl == '0) || (gate_ctrl == GATE_ON));

   // R9
   no_restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (core_ctrl != 8'h33) || $stable(core_ctrl));

endmodule

bind core_pwrup_seq core_pwrup_seq_chk #(
   .GATE_W       (GATE_W),
   .HS_COUNT     (HS_COUNT),
   .HS_COUNT_LSB (HS_COUNT_LSB)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .core_ctrl (core_ctrl),
   .gate_ctrl (gate_ctrl),
   .busy      (busy),
   .done      (done)
);

// File: tb/core_pwrup_seq_tb.sv
module core_pwrup_seq_tb;

   localparam int CPU = 3;
   localparam int W   = 2 * CPU;
   localparam logic [31:0] GATE_ON = 32'h1000_0001;

   typedef struct {
      int          cyc;
      logic [7:0]  ctrl;
      logic [31:0] gate;
      logic        busy;
      logic        done;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  core_ctrl;
   logic [31:0] gate_ctrl;
   logic        busy;
   logic        done;

   int   cyc = 0;
   int   n_tests = 0;
   int   n_fail = 0;
   bit   mon_en = 1'b0;
   exp_t sb_q[$];

   logic [7:0]  prev_ctrl;
   logic [31:0] prev_gate;
   logic        prev_busy;
   logic        prev_done;

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   core_pwrup_seq #(.CYCLES_PER_US(CPU)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .core_ctrl (core_ctrl),
      .gate_ctrl (gate_ctrl),
      .busy      (busy),
      .done      (done)
   );

   task automatic push(input int c, input logic [7:0] ct, input logic [31:0] g,
                       input logic b, input logic d, input string r);
      exp_t e;
      e.cyc = c; e.ctrl = ct; e.gate = g; e.busy = b; e.done = d; e.req = r;
      sb_q.push_back(e);
   endtask

   // driver: issue a start and queue every output change it must cause
   task automatic run_seq();
      int t0;
      @(negedge clk); #1;
      start = 1'b1;
      t0 = cyc + 1;
      push(t0,           8'h33, 32'h0,   1'b1, 1'b0, "R2");
      push(t0 + 1,       8'h33, GATE_ON, 1'b1, 1'b0, "R3");
      push(t0 + 1 + W,   8'h31, GATE_ON, 1'b1, 1'b0, "R4");
      push(t0 + 2 + W,   8'h39, GATE_ON, 1'b1, 1'b0, "R5");
      push(t0 + 2 + 2*W, 8'h38, GATE_ON, 1'b1, 1'b0, "R6");
      push(t0 + 2 + 3*W, 8'h08, GATE_ON, 1'b1, 1'b0, "R7");
      push(t0 + 3 + 3*W, 8'h88, GATE_ON, 1'b0, 1'b1, "R8");
      push(t0 + 4 + 3*W, 8'h88, GATE_ON, 1'b0, 1'b0, "R8");
      @(negedge clk); #1;
      start = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); #1;
      start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
   endtask

   task automatic wait_drain();
      while (sb_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic check_hold(input string r);
      n_tests++;
      if (core_ctrl !== 8'h88 || gate_ctrl !== GATE_ON || busy !== 1'b0 || done !== 1'b0) begin
         n_fail++;
         $display("FAIL %s hold: ctrl=%h gate=%h busy=%b done=%b expected ctrl=88 gate=%h busy=0 done=0",
                  r, core_ctrl, gate_ctrl, busy, done, GATE_ON);
      end
   endtask

   // monitor: every change of the outputs must match the head of the queue
   always @(negedge clk) begin
      if (mon_en) begin
         if (core_ctrl !== prev_ctrl || gate_ctrl !== prev_gate ||
             busy !== prev_busy || done !== prev_done) begin
            n_tests++;
            if (sb_q.size() == 0) begin
               n_fail++;
               $display("FAIL R9/R11 unexpected change at cycle %0d: ctrl=%h gate=%h busy=%b done=%b expected no change",
                        cyc, core_ctrl, gate_ctrl, busy, done);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               if (e.cyc != cyc || e.ctrl !== core_ctrl || e.gate !== gate_ctrl ||
                   e.busy !== busy || e.done !== done) begin
                  n_fail++;
                  $display("FAIL %s: cycle=%0d ctrl=%h gate=%h busy=%b done=%b expected cycle=%0d ctrl=%h gate=%h busy=%b done=%b",
                           e.req, cyc, core_ctrl, gate_ctrl, busy, done,
                           e.cyc, e.ctrl, e.gate, e.busy, e.done);
               end
            end
         end
      end
      prev_ctrl = core_ctrl;
      prev_gate = gate_ctrl;
      prev_busy = busy;
      prev_done = done;
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state held in reset
      n_tests++;
      if (core_ctrl !== 8'h00 || gate_ctrl !== 32'h0 || busy !== 1'b0 || done !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 reset: ctrl=%h gate=%h busy=%b done=%b expected all zero",
                  core_ctrl, gate_ctrl, busy, done);
      end
      #1 rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1: state right after release
      n_tests++;
      if (core_ctrl !== 8'h00 || gate_ctrl !== 32'h0 || busy !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 after release: ctrl=%h gate=%h busy=%b expected 00/0/0",
                  core_ctrl, gate_ctrl, busy);
      end
      mon_en = 1'b1;

      // pattern 1: plain run from reset
      run_seq();
      wait_drain();
      repeat (10) @(negedge clk);
      check_hold("R11");

      // pattern 2: back-to-back rerun from completed state (R11)
      run_seq();
      wait_drain();

      // pattern 3: stray starts while busy (R9)
      fork
         run_seq();
         begin
            repeat (4) @(negedge clk);
            pulse_start();
            repeat (W) @(negedge clk);
            pulse_start();
         end
      join
      wait_drain();
      check_hold("R9");

      // pattern 4: reset in the middle of a wait (R1)
      run_seq();
      repeat (W) @(negedge clk);
      #1;
      sb_q.delete();
      push(cyc + 1, 8'h00, 32'h0, 1'b0, 1'b0, "R1");
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      repeat (W * 4) @(negedge clk);
      n_tests++;
      if (sb_q.size() != 0 || busy !== 1'b0 || core_ctrl !== 8'h00) begin
         n_fail++;
         $display("FAIL R1 mid-run reset: pending=%0d busy=%b ctrl=%h expected 0/0/00",
                  sb_q.size(), busy, core_ctrl);
      end

      // a fresh run after the aborted one
      run_seq();
      wait_drain();
      check_hold("R11");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule